// File: doc/BRIEF.md
# Reloadable Interval Timer

This block is a 16-bit down-counter paired with a 16-bit reload value. A host programs it through four byte-wide locations on a small synchronous bus. When the count passes through zero the block sends a one-clock set pulse to a separate interrupt flag and enable unit. Some bus accesses send that unit a one-clock clear pulse instead. The block stores no flag of its own.

A write to the counter-high location starts the timer. That write completes the reload value, copies it into the counter and arms the interrupt. Bit 6 of the auxiliary control input selects the run mode. In free-running mode the counter reloads after each wrap, so the pulses repeat every reload+2 clock enables. In one-shot mode only the first wrap after arming produces a pulse, and the counter then keeps counting down. A clock-enable input sets the count rate.

Top module: `ivl_timer`

## Requirements
- R1: After reset the reload value is 0xFFFF, the counter reads 0x0000 and does not count, the mode is one-shot, and no set pulse appears until the timer is started.
- R2: A write to offset 0 (counter-low) or offset 2 (reload-low) changes only bits 7:0 of the reload value. It does not touch the counter and gives no clear pulse.
- R3: A write to offset 1 (counter-high) stores the byte into bits 15:8 of the reload value and loads the complete new reload value into the counter. It arms the timer and gives a clear pulse one clock later.
- R4: A write to offset 3 (reload-high) stores the byte into bits 15:8 of the reload value and gives a clear pulse. It leaves the counter unchanged.
- R5: Read data is registered and appears one clock after the access. A read of offset 0 returns counter bits 7:0 and gives a clear pulse. A read of offset 1 returns counter bits 15:8 and has no side effect.
- R6: Reads of offset 2 and offset 3 return the reload value's low and high bytes unchanged.
- R7: Once started, the counter decreases by one on each clock on which tick_en is high. It holds its value while tick_en is low.
- R8: A set pulse lasts one clock and appears one clock enable after the counter has gone from 0x0000 to 0xFFFF. In free-running mode, starting the timer with reload value N at clock W gives pulses at clocks W+k*(N+2) for k = 1, 2, 3, and so on.
- R9: aux_ctrl bit 6 = 1 selects free-running mode, in which the counter reloads after each pulse. Bit 6 = 0 selects one-shot mode, in which exactly one pulse occurs per start and the counter keeps decrementing past 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable |
| cs | input | 1 | Block select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| aux_ctrl | input | 8 | Auxiliary control; bit 6 selects run mode |
| flag_set | output | 1 | One-clock request to set the timer flag |
| flag_clr | output | 1 | One-clock request to clear the timer flag |

## Verification
The bench sweeps reload values 0 to 9 and 37 in free-running mode and checks the first three pulse times against W+k*(N+2). A design that fired on reaching 0x0000, or that reloaded straight from 0xFFFF without the extra clock, would put every pulse one clock early. A design that fired on the 0xFFFF clock itself would show a period of N+1. In one-shot mode the bench requires exactly one pulse and then compares the read-back counter with the wrapped arithmetic value; a design that stopped or reloaded would fail that comparison. With tick_en held low, the bench checks that the low-byte writes and the reload-high write leave the counter untouched, so a decode that loaded the counter on the wrong offset is caught.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      OFS_CNT_LO = 2'd0,
      OFS_CNT_HI = 2'd1,
      OFS_RLD_LO = 2'd2,
      OFS_RLD_HI = 2'd3
   } tmr_ofs_e;
endpackage

// File: rtl/tmr_bus.sv
module tmr_bus
   import tmr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NBYTES = 2,
   localparam int CNT_W = DATA_W * NBYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CNT_W-1:0]  rld,
   output logic [NBYTES-1:0] byte_we,
   output logic              load,
   output logic [DATA_W-1:0] rdata,
   output logic              flag_clr
);
   logic wr_acc, rd_acc, clr_nxt;
   logic [DATA_W-1:0] rd_mux;
   tmr_ofs_e ofs;

   assign ofs    = tmr_ofs_e'(addr);
   assign wr_acc = cs & wr_en;
   assign rd_acc = cs & rd_en & ~wr_en;

   assign byte_we[0] = wr_acc & ((ofs == OFS_CNT_LO) | (ofs == OFS_RLD_LO));
   assign byte_we[1] = wr_acc & ((ofs == OFS_CNT_HI) | (ofs == OFS_RLD_HI));
   assign load       = wr_acc & (ofs == OFS_CNT_HI);
   assign clr_nxt    = (wr_acc & ((ofs == OFS_CNT_HI) | (ofs == OFS_RLD_HI)))
                     | (rd_acc & (ofs == OFS_CNT_LO));

   always_comb begin
      unique case (ofs)
         OFS_CNT_LO: rd_mux = cnt[DATA_W-1:0];
         OFS_CNT_HI: rd_mux = cnt[CNT_W-1:DATA_W];
         OFS_RLD_LO: rd_mux = rld[DATA_W-1:0];
         default:    rd_mux = rld[CNT_W-1:DATA_W];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata    <= '0;
         flag_clr <= 1'b0;
      end else begin
         flag_clr <= clr_nxt;
         if (rd_acc) rdata <= rd_mux;
      end
   end

   assert_clr_on_low_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && rd_en && !wr_en && addr == 2'd0) |=> flag_clr);
   assert_quiet_high_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && rd_en && !wr_en && addr == 2'd1) |=> !flag_clr);
endmodule

// File: rtl/tmr_reload.sv
module tmr_reload #(
   parameter int DATA_W = 8,
   parameter int NBYTES = 2,
   localparam int CNT_W = DATA_W * NBYTES,
   parameter logic [CNT_W-1:0] RLD_INIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NBYTES-1:0] byte_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  rld
);
   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      always_ff @(posedge clk) begin
         if (!rst_n)          rld[b*DATA_W +: DATA_W] <= RLD_INIT[b*DATA_W +: DATA_W];
         else if (byte_we[b]) rld[b*DATA_W +: DATA_W] <= wdata;
      end
   end

   assert_reload_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_we == '0) |=> $stable(rld));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] rld,
   input  logic             free_run,
   output logic [CNT_W-1:0] cnt,
   output logic             fire
);
   logic running, armed, pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
         armed   <= 1'b0;
         pend    <= 1'b0;
         fire    <= 1'b0;
      end else if (load) begin
         cnt     <= load_val;
         running <= 1'b1;
         armed   <= 1'b1;
         pend    <= 1'b0;
         fire    <= 1'b0;
      end else begin
         fire <= 1'b0;
         if (running && tick) begin
            if (pend) begin
               fire <= 1'b1;
               pend <= 1'b0;
               if (free_run) begin
                  cnt <= rld;
               end else begin
                  cnt   <= cnt - CNT_W'(1);
                  armed <= 1'b0;
               end
            end else begin
               cnt <= cnt - CNT_W'(1);
               if (armed && cnt == '0) pend <= 1'b1;
            end
         end
      end
   end

   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)));
   assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick && !load && !pend) |=> (cnt == $past(cnt) - CNT_W'(1)));
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt));
   assert_pulse_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);
   assert_oneshot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick && pend && !free_run && !load) |=> !armed);
   assert_stopped_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (!pend && !fire));
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer #(
   parameter int DATA_W  = 8,
   parameter int AUX_W   = 8,
   parameter int RUN_BIT = 6,
   localparam int NBYTES = 2,
   localparam int CNT_W  = DATA_W * NBYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              cs,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [AUX_W-1:0]  aux_ctrl,
   output logic              flag_set,
   output logic              flag_clr
);
   if (RUN_BIT >= AUX_W) begin : g_bad_runbit
      $error("RUN_BIT must index into aux_ctrl");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic [NBYTES-1:0] byte_we;
   logic              load;
   logic [CNT_W-1:0]  cnt, rld, load_val;
   logic              free_run;
   logic              aux_unused;

   assign free_run   = aux_ctrl[RUN_BIT];
   assign aux_unused = ^aux_ctrl;
   assign load_val   = {wdata, rld[DATA_W-1:0]};

   tmr_bus #(.DATA_W(DATA_W), .NBYTES(NBYTES)) u_bus (
      .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .cnt(cnt), .rld(rld), .byte_we(byte_we), .load(load),
      .rdata(rdata), .flag_clr(flag_clr)
   );

   tmr_reload #(.DATA_W(DATA_W), .NBYTES(NBYTES)) u_rld (
      .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .wdata(wdata), .rld(rld)
   );

   tmr_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .load(load),
      .load_val(load_val), .rld(rld), .free_run(free_run),
      .cnt(cnt), .fire(flag_set)
   );
endmodule

// File: tb/ivl_timer_test.sv
module ivl_timer_test;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, tick_en, cs, wr_en, rd_en, flag_set, flag_clr;
   logic [1:0] addr;
   logic [7:0] wdata, rdata, aux_ctrl;

   ivl_timer uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cs(cs), .wr_en(wr_en),
      .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .aux_ctrl(aux_ctrl), .flag_set(flag_set), .flag_clr(flag_clr)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int tests = 0, fails = 0;
   int plog[16];
   int pn = 0;
   always @(negedge clk) if (flag_set) begin
      if (pn < 16) plog[pn] = cyc;
      pn = pn + 1;
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d,
                         output logic clr, output int wc);
      @(negedge clk);
      cs = 1; wr_en = 1; addr = a; wdata = d;
      @(negedge clk);
      cs = 0; wr_en = 0;
      clr = flag_clr;
      wc = cyc;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] v,
                         output logic clr, output int rc);
      @(negedge clk);
      cs = 1; rd_en = 1; addr = a; rc = cyc;
      @(negedge clk);
      cs = 0; rd_en = 0;
      v = rdata;
      clr = flag_clr;
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic c;
      logic [7:0] v;
      int w, rc, c0, n, expv;
      rst_n = 0; tick_en = 1; cs = 0; wr_en = 0; rd_en = 0;
      addr = 0; wdata = 0; aux_ctrl = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      bus_rd(2'd2, v, c, rc); chk("R1 reload lo", v, 8'hFF);
      bus_rd(2'd3, v, c, rc); chk("R1 reload hi", v, 8'hFF);
      repeat (10) @(negedge clk);
      bus_rd(2'd0, v, c, rc); chk("R1 counter lo stopped", v, 0);
      bus_rd(2'd1, v, c, rc); chk("R1 counter hi", v, 0);
      chk("R1 no pulse", pn, 0);

      // R8/R9 free-running sweep
      aux_ctrl = 8'h40;
      for (int k = 0; k < 11; k++) begin
         n = (k < 10) ? k : 37;
         bus_wr(2'd2, 8'(n), c, w);
         bus_wr(2'd1, 8'h00, c, w);
         chk("R3 clear on counter-high write", c, 1);
         #1 pn = 0;
         repeat (3 * (n + 2) + 1) @(negedge clk);
         #1;
         chk("R8 pulse count", pn, 3);
         for (int j = 0; j < 3; j++)
            chk("R8 R9 pulse time", plog[j] - w, (n + 2) * (j + 1));
      end

      // R9 one-shot
      aux_ctrl = 8'hBF;
      n = 4;
      bus_wr(2'd2, 8'(n), c, w);
      bus_wr(2'd3, 8'h00, c, w);
      bus_wr(2'd1, 8'h00, c, w);
      #1 pn = 0;
      repeat (30) @(negedge clk);
      #1;
      chk("R9 one-shot single pulse", pn, 1);
      chk("R8 one-shot pulse time", plog[0] - w, n + 2);
      bus_rd(2'd1, v, c, rc);
      expv = (n - (rc - w)) & 16'hFFFF;
      chk("R9 keeps counting hi", v, (expv >> 8) & 8'hFF);
      chk("R5 no clear on high read", c, 0);
      bus_rd(2'd0, v, c, rc);
      expv = (n - (rc - w)) & 16'hFFFF;
      chk("R9 keeps counting lo", v, expv & 8'hFF);
      chk("R5 clear on low read", c, 1);

      // R7 tick gating, R2 R4 R6 with counter frozen
      n = 10;
      bus_wr(2'd2, 8'(n), c, w);
      bus_wr(2'd1, 8'h00, c, w);
      tick_en = 0;
      repeat (5) @(negedge clk);
      bus_rd(2'd0, v, c, rc); chk("R7 hold when tick low", v, n);
      bus_wr(2'd0, 8'h5A, c, w); chk("R2 no clear on low write", c, 0);
      bus_rd(2'd2, v, c, rc); chk("R2 R6 reload lo via offset 0", v, 8'h5A);
      bus_rd(2'd0, v, c, rc); chk("R2 counter untouched", v, n);
      bus_wr(2'd2, 8'h3C, c, w);
      bus_rd(2'd2, v, c, rc); chk("R2 R6 reload lo via offset 2", v, 8'h3C);
      bus_wr(2'd3, 8'h12, c, w); chk("R4 clear on reload-high write", c, 1);
      bus_rd(2'd1, v, c, rc); chk("R4 counter hi unchanged", v, 0);
      bus_rd(2'd0, v, c, rc); chk("R4 counter lo unchanged", v, n);
      bus_rd(2'd3, v, c, rc); chk("R6 reload hi", v, 8'h12);
      chk("R7 no pulse while frozen", pn, 1);
      @(negedge clk);
      tick_en = 1; c0 = cyc;
      repeat (4) @(negedge clk);
      bus_rd(2'd0, v, c, rc); chk("R7 decrement per tick", v, n - (rc - c0));

      // R3 counter-high write loads new full reload value
      tick_en = 0;
      bus_wr(2'd1, 8'h03, c, w);
      bus_rd(2'd1, v, c, rc); chk("R3 counter hi loaded", v, 8'h03);
      bus_rd(2'd0, v, c, rc); chk("R3 counter lo loaded", v, 8'h3C);
      bus_rd(2'd3, v, c, rc); chk("R3 reload hi stored", v, 8'h03);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule